// File: doc/BRIEF.md
# Quadrature Sine/Cosine Generator

This block turns a phase word into a pair of 16-bit two's-complement samples: the sine and the cosine of that phase. The top 20 bits of a 32-bit phase word form an angle address. The address divides one full turn into 2^20 equal steps, so address 0 is zero radians and the largest address sits one step short of a full turn. The two most significant address bits pick the quadrant. The remaining 18 bits are rotated by a pipelined shift-and-add rotation engine, which works only inside the first quadrant. A fold stage then swaps and negates the two results to place the vector in the right quadrant. No lookup table is stored.

The output scale is symmetric. Full-scale positive is 32767 and full-scale negative is -32767, so the most negative two's-complement code never appears on the trigonometric path. A per-sample mode input can replace the trigonometric results with the raw phase word. The upper half of the word then appears on the cosine bus and the lower half on the sine bus, which lets a downstream stage observe the accumulator directly. Data and mode travel through the pipeline together, so consecutive samples may use different modes. The block accepts one sample every clock.

Top module: `sincos_gen`

## Requirements
- R1: With trig_sel high, sin_o and cos_o lie within 2 LSB of round(32767·sin θ) and round(32767·cos θ). Here θ = 2π·A/2^20, and A is phase_i[31:12] read as an unsigned number.
- R2: With trig_sel high, both outputs stay in -32767..32767, and the code 0x8000 never appears.
- R3: Adding 2^18 to A gives exact quadrant relations. The new sine equals the old cosine, and the new cosine equals the old sine negated. Adding 2^19 negates both outputs. Adding 3·2^18 gives a sine equal to the old cosine negated and a cosine equal to the old sine.
- R4: With trig_sel low for a sample, cos_o carries phase_i[31:16] and sin_o carries phase_i[15:0] unchanged. The mode is chosen per sample.
- R5: Each sample accepted with in_valid high appears with out_valid high exactly 20 clock cycles later (iterations + 2).
- R6: While rst_n is low, and after its release until the first result, out_valid, sin_o and cos_o are all zero.
- R7: While out_valid is low, sin_o and cos_o keep their last values.
- R8: With trig_sel high, phase_i[11:0] has no effect on the outputs.
- R9: One sample is accepted per clock with no gaps, and every accepted sample produces exactly one output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Sample present on phase_i this cycle |
| phase_i | input | 32 | Phase word; bits 31:12 form the angle address |
| trig_sel | input | 1 | 1 = sine/cosine, 0 = raw phase onto the output buses |
| out_valid | output | 1 | Result present on sin_o/cos_o |
| sin_o | output | 16 | Sine sample, or phase bits 15:0 in raw mode |
| cos_o | output | 16 | Cosine sample, or phase bits 31:16 in raw mode |

## Verification
A back-to-back sweep of 65536 addresses, with a stride of 16 and a rotating low nibble, covers every quadrant boundary, zero and the last address. Each result is compared with a real-valued model, which exposes gain, angle-table and rounding faults. Quadruples of addresses one quarter turn apart are compared with each other exactly, which separates fold-stage errors from rotation-engine errors. Pairs that differ only in the ignored low phase bits show whether those bits leak into the result. Raw-mode words such as 0x80000000 and 0xFFFFFFFF, interleaved with trigonometric samples, test that the mode stays attached to its sample and that the range clamp never touches the bypass path.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam real SC_PI = 3.14159265358979323846;

  typedef enum logic [1:0] {
    Q_FIRST  = 2'd0,
    Q_SECOND = 2'd1,
    Q_THIRD  = 2'd2,
    Q_FOURTH = 2'd3
  } quad_e;

  // arctangent of 2^-i, radians, by power series (i >= 1 keeps x <= 0.5)
  function automatic real atan_pow2(input int i);
    real x, t, s;
    if (i == 0) return SC_PI / 4.0;
    x = 1.0 / (2.0 ** i);
    s = 0.0;
    t = x;
    for (int k = 0; k < 40; k++) begin
      s = s + (((k % 2) == 1) ? -1.0 : 1.0) * t / real'(2 * k + 1);
      t = t * x * x;
    end
    return s;
  endfunction

  // rotation step angle in binary-angle units (2^zw per turn)
  function automatic int angle_code(input int i, input int zw);
    real a;
    a = atan_pow2(i) / (2.0 * SC_PI) * (2.0 ** zw);
    return $rtoi(a + 0.5);
  endfunction

  // total magnitude growth of n rotation steps
  function automatic real chain_gain(input int n);
    real p, r;
    p = 1.0;
    for (int i = 0; i < n; i++) p = p * (1.0 + 1.0 / (4.0 ** i));
    r = p;
    for (int k = 0; k < 40; k++) r = 0.5 * (r + p / r);
    return r;
  endfunction

  // pre-scaled starting x so that the result lands on the full-scale amplitude
  function automatic int start_x(input int out_w, input int guard, input int n);
    real amp;
    amp = (2.0 ** (out_w - 1)) - 1.0;
    return $rtoi(amp * (2.0 ** guard) / chain_gain(n) + 0.5);
  endfunction

endpackage

// File: rtl/sc_cordic_stage.sv
module sc_cordic_stage #(
  parameter int IW    = 23,
  parameter int ZW    = 24,
  parameter int STAGE = 0
) (
  input  logic                 clk,
  input  logic                 en,
  input  logic signed [IW-1:0] x_i,
  input  logic signed [IW-1:0] y_i,
  input  logic signed [ZW-1:0] z_i,
  output logic signed [IW-1:0] x_o,
  output logic signed [IW-1:0] y_o,
  output logic signed [ZW-1:0] z_o
);

  localparam int                 ANG_I = sc_pkg::angle_code(STAGE, ZW);
  localparam logic signed [ZW-1:0] ANG = ZW'(ANG_I);

  logic signed [IW-1:0] xsh, ysh, x_d, y_d;
  logic signed [ZW-1:0] z_d;

  always_comb begin
    xsh = x_i >>> STAGE;
    ysh = y_i >>> STAGE;
    if (!z_i[ZW-1]) begin
      x_d = x_i - ysh;
      y_d = y_i + xsh;
      z_d = z_i - ANG;
    end else begin
      x_d = x_i + ysh;
      y_d = y_i - xsh;
      z_d = z_i + ANG;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      x_o <= x_d;
      y_o <= y_d;
      z_o <= z_d;
    end
  end

endmodule

// File: rtl/sc_tag_pipe.sv
module sc_tag_pipe #(
  parameter int W     = 33,
  parameter int DEPTH = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld_i,
  input  logic [W-1:0]     dat_i,
  output logic [DEPTH-1:0] vld_o,
  output logic [W-1:0]     dat_o
);

  logic         vld_q [DEPTH];
  logic [W-1:0] dat_q [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_st
    logic         v_in;
    logic [W-1:0] d_in;

    if (k == 0) begin : g_head
      assign v_in = vld_i;
      assign d_in = dat_i;
    end else begin : g_body
      assign v_in = vld_q[k-1];
      assign d_in = dat_q[k-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q[k] <= 1'b0;
      else        vld_q[k] <= v_in;
    end

    always_ff @(posedge clk) begin
      if (v_in) dat_q[k] <= d_in;
    end

    assign vld_o[k] = vld_q[k];
  end

  assign dat_o = dat_q[DEPTH-1];

endmodule

// File: rtl/sc_fold.sv
module sc_fold #(
  parameter int IW    = 23,
  parameter int OUT_W = 16,
  parameter int GUARD = 5
) (
  input  logic signed [IW-1:0]    x_i,
  input  logic signed [IW-1:0]    y_i,
  input  logic [1:0]              quad_i,
  output logic signed [OUT_W-1:0] sin_o,
  output logic signed [OUT_W-1:0] cos_o
);

  localparam int                  AMP     = (2 ** (OUT_W - 1)) - 1;
  localparam logic signed [IW-1:0] HALF    = IW'(2 ** (GUARD - 1));
  localparam logic signed [IW-1:0] POS_LIM = IW'(AMP);
  localparam logic signed [IW-1:0] NEG_LIM = -POS_LIM;

  function automatic logic signed [OUT_W-1:0] scale(input logic signed [IW-1:0] v);
    logic signed [IW-1:0] r;
    r = (v + HALF) >>> GUARD;
    if (r > POS_LIM)      return POS_LIM[OUT_W-1:0];
    else if (r < NEG_LIM) return NEG_LIM[OUT_W-1:0];
    else                  return r[OUT_W-1:0];
  endfunction

  logic signed [OUT_W-1:0] xs, ys;

  always_comb begin
    xs = scale(x_i);
    ys = scale(y_i);
    unique case (sc_pkg::quad_e'(quad_i))
      sc_pkg::Q_FIRST:  begin sin_o = ys;  cos_o = xs;  end
      sc_pkg::Q_SECOND: begin sin_o = xs;  cos_o = -ys; end
      sc_pkg::Q_THIRD:  begin sin_o = -ys; cos_o = -xs; end
      default:          begin sin_o = -xs; cos_o = ys;  end
    endcase
  end

endmodule

// File: rtl/sincos_gen.sv
module sincos_gen #(
  parameter int PH_W   = 32,
  parameter int ADDR_W = 20,
  parameter int OUT_W  = 16,
  parameter int GUARD  = 5,
  parameter int ITER   = 18,
  parameter int ZW     = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [PH_W-1:0]         phase_i,
  input  logic                    trig_sel,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] sin_o,
  output logic signed [OUT_W-1:0] cos_o
);

  localparam int IW    = OUT_W + GUARD + 2;
  localparam int RES_W = ADDR_W - 2;
  localparam int PAD_W = ZW - ADDR_W;
  localparam int TAG_W = PH_W + 1;
  localparam int LAT   = ITER + 2;
  localparam int X0_I  = sc_pkg::start_x(OUT_W, GUARD, ITER);
  localparam logic signed [IW-1:0] X0 = IW'(X0_I);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q_n    <= rst_meta_q;
    end
  end

  // first-quadrant residual angle, binary-angle units
  logic signed [ZW-1:0] z0_d, z0_q;
  assign z0_d = $signed({2'b00, phase_i[PH_W-3 -: RES_W], {PAD_W{1'b0}}});

  always_ff @(posedge clk) begin
    if (in_valid) z0_q <= z0_d;
  end

  // valid, mode and raw phase travel alongside the rotation
  logic [ITER:0]      tvld;
  logic [TAG_W-1:0]   tag_dat;

  sc_tag_pipe #(.W(TAG_W), .DEPTH(ITER + 1)) u_tag (
    .clk   (clk),
    .rst_n (rst_q_n),
    .vld_i (in_valid),
    .dat_i ({trig_sel, phase_i}),
    .vld_o (tvld),
    .dat_o (tag_dat)
  );

  logic signed [IW-1:0] xs [ITER+1];
  logic signed [IW-1:0] ys [ITER+1];
  logic signed [ZW-1:0] zs [ITER+1];

  assign xs[0] = X0;
  assign ys[0] = '0;
  assign zs[0] = z0_q;

  for (genvar k = 0; k < ITER; k++) begin : g_rot
    sc_cordic_stage #(.IW(IW), .ZW(ZW), .STAGE(k)) u_stage (
      .clk (clk),
      .en  (tvld[k]),
      .x_i (xs[k]),
      .y_i (ys[k]),
      .z_i (zs[k]),
      .x_o (xs[k+1]),
      .y_o (ys[k+1]),
      .z_o (zs[k+1])
    );
  end

  logic signed [OUT_W-1:0] f_sin, f_cos;

  sc_fold #(.IW(IW), .OUT_W(OUT_W), .GUARD(GUARD)) u_fold (
    .x_i    (xs[ITER]),
    .y_i    (ys[ITER]),
    .quad_i (tag_dat[PH_W-1 -: 2]),
    .sin_o  (f_sin),
    .cos_o  (f_cos)
  );

  logic signed [OUT_W-1:0] sin_d, cos_d;

  always_comb begin
    if (tag_dat[PH_W]) begin
      sin_d = f_sin;
      cos_d = f_cos;
    end else begin
      sin_d = $signed(tag_dat[OUT_W-1:0]);
      cos_d = $signed(tag_dat[PH_W-1 -: OUT_W]);
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      out_valid <= 1'b0;
      sin_o     <= '0;
      cos_o     <= '0;
    end else begin
      out_valid <= tvld[ITER];
      if (tvld[ITER]) begin
        sin_o <= sin_d;
        cos_o <= cos_d;
      end
    end
  end

endmodule

// File: rtl/sincos_gen_chk.sv
module sincos_gen_chk #(
  parameter int LAT   = 20,
  parameter int OUT_W = 16,
  parameter int PH_W  = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic [PH_W-1:0]         phase_i,
  input logic                    trig_sel,
  input logic                    out_valid,
  input logic signed [OUT_W-1:0] sin_o,
  input logic signed [OUT_W-1:0] cos_o
);

  localparam longint AMP   = (longint'(1) << (OUT_W - 1)) - 1;
  localparam longint RAD2  = AMP * AMP;
  localparam longint TOL   = 5 * AMP;
  localparam logic [OUT_W-1:0] MINC = {1'b1, {(OUT_W-1){1'b0}}};

  logic            cv [LAT];
  logic            cm [LAT];
  logic [PH_W-1:0] cp [LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) cv[i] <= 1'b0;
    end else begin
      cv[0] <= in_valid;
      for (int i = 1; i < LAT; i++) cv[i] <= cv[i-1];
    end
  end

  always_ff @(posedge clk) begin
    cm[0] <= trig_sel;
    cp[0] <= phase_i;
    for (int i = 1; i < LAT; i++) begin
      cm[i] <= cm[i-1];
      cp[i] <= cp[i-1];
    end
  end

  longint mag_err;
  always_comb begin
    mag_err = longint'(sin_o) * longint'(sin_o) + longint'(cos_o) * longint'(cos_o) - RAD2;
  end

  a_r5_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == cv[LAT-1]);

  a_r4_bypass_raw: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !cm[LAT-1]) |->
      ($unsigned(cos_o) == cp[LAT-1][PH_W-1 -: OUT_W] && $unsigned(sin_o) == cp[LAT-1][OUT_W-1:0]));

  a_r2_no_min_code: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cm[LAT-1]) |-> ($unsigned(sin_o) != MINC && $unsigned(cos_o) != MINC));

  a_r1_unit_circle: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cm[LAT-1]) |-> (mag_err <= TOL && mag_err >= -TOL));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(sin_o) && $stable(cos_o)));

  a_r6_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && sin_o == '0 && cos_o == '0));

endmodule

bind sincos_gen sincos_gen_chk #(.LAT(LAT), .OUT_W(OUT_W), .PH_W(PH_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .in_valid  (in_valid),
  .phase_i   (phase_i),
  .trig_sel  (trig_sel),
  .out_valid (out_valid),
  .sin_o     (sin_o),
  .cos_o     (cos_o)
);

// File: tb/sim_sincos_gen.sv
`timescale 1ns/1ps
module sim_sincos_gen;

  localparam int LAT = 20;
  localparam logic [19:0] QTR = 20'h40000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] phase_i;
  logic        trig_sel;
  logic        out_valid;
  logic signed [15:0] sin_o, cos_o;

  always #2.5 clk = ~clk;

  sincos_gen u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .phase_i   (phase_i),
    .trig_sel  (trig_sel),
    .out_valid (out_valid),
    .sin_o     (sin_o),
    .cos_o     (cos_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  int n_in  = 0;
  int n_out = 0;
  bit done  = 0;

  logic [31:0]        r_ph [64];
  bit                 r_md [64];
  int                 r_st [64];
  logic signed [15:0] g_s  [64];
  logic signed [15:0] g_c  [64];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint got, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int model(input logic [19:0] a, input bit want_sin);
    real ang, v;
    ang = 2.0 * 3.14159265358979323846 * real'(a) / 1048576.0;
    v = want_sin ? $sin(ang) : $cos(ang);
    return int'(32767.0 * v);
  endfunction

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic send(input logic [31:0] ph, input bit md);
    @(negedge clk);
    in_valid = 1'b1;
    phase_i  = ph;
    trig_sel = md;
    r_ph[n_in % 64] = ph;
    r_md[n_in % 64] = md;
    r_st[n_in % 64] = cyc;
    n_in++;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // output monitor, sampled away from the rising edge
  always @(negedge clk) begin
    int k, es, ec, ds, dc;
    if (out_valid) begin
      k = n_out % 64;
      chk((cyc - r_st[k]) == LAT, "R5 latency", cyc - r_st[k], LAT);
      if (r_md[k]) begin
        es = model(r_ph[k][31:12], 1'b1);
        ec = model(r_ph[k][31:12], 1'b0);
        ds = int'(sin_o) - es;
        dc = int'(cos_o) - ec;
        chk(ds <= 2 && ds >= -2, "R1 sine", sin_o, es);
        chk(dc <= 2 && dc >= -2, "R1 cosine", cos_o, ec);
        chk($unsigned(sin_o) != 16'h8000 && $unsigned(cos_o) != 16'h8000,
            "R2 range", $unsigned(sin_o), es);
      end else begin
        chk($unsigned(sin_o) == r_ph[k][15:0], "R4 raw sine bus", $unsigned(sin_o), r_ph[k][15:0]);
        chk($unsigned(cos_o) == r_ph[k][31:16], "R4 raw cosine bus", $unsigned(cos_o), r_ph[k][31:16]);
      end
      g_s[k] = sin_o;
      g_c[k] = cos_o;
      n_out++;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R9 watchdog: got %0d outputs expected %0d", n_out, n_in);
      report();
      $finish;
    end
  end

  initial begin
    logic signed [15:0] hs, hc;
    int base;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    phase_i  = '0;
    trig_sel = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R6 valid in reset", out_valid, 0);
    chk(sin_o == 0 && cos_o == 0, "R6 data in reset", sin_o, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(out_valid == 1'b0 && sin_o == 0 && cos_o == 0, "R6 after release", out_valid, 0);

    // R4: raw mode interleaved with trig samples
    send(32'h8000_0000, 1'b0);
    send(32'hFFFF_FFFF, 1'b0);
    send(32'h4000_0000, 1'b1);
    send(32'h1234_5678, 1'b0);
    send(32'hC000_0ABC, 1'b1);
    send(32'hA5A5_5A5A, 1'b0);
    idle(LAT + 4);

    // R7: outputs hold while idle
    hs = sin_o;
    hc = cos_o;
    idle(12);
    chk(sin_o == hs && hs == 16'sh5A5A, "R7 hold sine", sin_o, hs);
    chk(cos_o == hc, "R7 hold cosine", cos_o, hc);

    // R8: low phase bits ignored
    base = n_in;
    send({20'h2B3C1, 12'h000}, 1'b1);
    send({20'h2B3C1, 12'hFFF}, 1'b1);
    send({20'h2B3C1, 12'h7A5}, 1'b1);
    idle(LAT + 4);
    for (int j = 1; j < 3; j++) begin
      chk(g_s[(base + j) % 64] == g_s[base % 64], "R8 sine", g_s[(base + j) % 64], g_s[base % 64]);
      chk(g_c[(base + j) % 64] == g_c[base % 64], "R8 cosine", g_c[(base + j) % 64], g_c[base % 64]);
    end

    // R3: exact quadrant relations
    for (int t = 0; t < 4; t++) begin
      logic [19:0] a;
      int i0, i1, i2, i3;
      a = (t == 0) ? 20'h00000 : (t == 1) ? 20'h12345 : (t == 2) ? 20'h3FFFF : 20'h2AAAA;
      base = n_in;
      for (int j = 0; j < 4; j++) send({a + 20'(j) * QTR, 12'h000}, 1'b1);
      idle(LAT + 4);
      i0 = base % 64; i1 = (base + 1) % 64; i2 = (base + 2) % 64; i3 = (base + 3) % 64;
      chk(g_s[i1] == g_c[i0],  "R3 q2 sine",   g_s[i1], g_c[i0]);
      chk(g_c[i1] == -g_s[i0], "R3 q2 cosine", g_c[i1], -g_s[i0]);
      chk(g_s[i2] == -g_s[i0], "R3 q3 sine",   g_s[i2], -g_s[i0]);
      chk(g_c[i2] == -g_c[i0], "R3 q3 cosine", g_c[i2], -g_c[i0]);
      chk(g_s[i3] == -g_c[i0], "R3 q4 sine",   g_s[i3], -g_c[i0]);
      chk(g_c[i3] == g_s[i0],  "R3 q4 cosine", g_c[i3], g_s[i0]);
    end

    // R1/R9: back-to-back sweep, includes 0, quarter points and 0xFFFFF
    for (int k = 0; k < 65536; k++) begin
      logic [19:0] ad;
      ad = 20'(k << 4) | 20'(k & 15);
      send({ad, 12'(k * 37)}, 1'b1);
    end
    idle(LAT + 4);

    chk(n_out == n_in, "R9 sample count", n_out, n_in);
    done = 1'b1;
    report();
    $finish;
  end

endmodule